// File: doc/BRIEF.md
# Performance Event Counter Unit

This unit keeps a bank of 32-bit event counters (parameter `NUM_CNT`, 1 to 31) and one cycle counter that can be 32 or 64 bits long. Software programs it through a single-cycle register port with a 4-bit word address. Each event counter has its own increment strobe, `evt_in[i]`, which is high for one clock per event. The cycle counter advances on every clock while it is allowed to count. Three mask registers each have a set address and a clear address: counter enable, interrupt enable and overflow status. Bit `i` in these masks belongs to event counter `i`, and bit 31 belongs to the cycle counter.

Each counter has a six-bit privilege filter. The filter is evaluated against the current exception level (`el`, 0 to 3) and the `secure` input, and it can stop the counter. A counter that wraps sets its overflow-status bit. The level interrupt `irq` follows the overflow-status and interrupt-enable masks as described in R6 and R7. A software-increment address advances any chosen counter whose event code is the software-increment code.

Top module: `perfmon_unit`

Register addresses: 0 control, 1/2 enable set/clear, 3/4 interrupt-enable set/clear, 5/6 overflow set/clear, 7 software increment, 8 select, 9 indirect type, 10 indirect count, 11/12 cycle counter low/high word.

## Requirements
- R1: A write to address 0 keeps only bit 0 (global enable), bit 3, bit 4 and bit 5 (cycle long mode), which together form mask 0x39. A read of address 0 returns those bits ORed with a fixed field: `ID_CODE` in bits 31:24 and `NUM_CNT` in bits 15:11.
- R2: A write to address 0 with bit 1 set zeroes every event counter. A write to address 0 with bit 2 set zeroes the cycle counter.
- R3: A counter advances only when control bit 0 and its own enable bit are both set. The cycle counter uses enable bit 31.
- R4: Set addresses OR the written value into their mask, and clear addresses AND the mask with the inverted value. Both addresses of a pair read the mask. Bits with no counter behind them read zero.
- R5: An event counter at 0xFFFFFFFF that increments becomes 0 and sets its overflow bit. The cycle counter sets overflow bit 31 on a carry out of bit 31 when long mode is off, or out of bit 63 when long mode is on. Overflow bits are removed only by the clear address.
- R6: An overflow raises `irq` when that counter's interrupt-enable bit is set. It leaves `irq` unchanged otherwise.
- R7: A write that takes the overflow mask from nonzero to zero drops `irq`. A write that takes it from zero to a value that shares a bit with interrupt-enable raises `irq`.
- R8: A write to address 7 adds 1 to every event counter whose bit is set in the data and whose event code (type bits 7:0) is `SW_CODE` (default 0). Address 7 reads as zero.
- R9: Type bits 31..26 are P, U, NSK, NSU, NSH and M. A counter is held under these conditions: at level 0, on U when secure, otherwise on U xor NSU; at level 1, on P when secure, otherwise on P xor NSK; at level 2, when NSH is 0; at level 3, on P xor M.
- R10: Type writes with select value 31 change only the cycle counter's filter bits, and a read at that select returns `CYC_CODE` in bits 7:0. Type and count accesses to a select value with no counter are ignored and read as zero.
- R11: The select register (address 8, 5 bits) chooses the counter that addresses 9 and 10 reach. Address 10 reads the selected event counter.
- R12: A software write to a counter (count write or reset bit) wins over an increment in the same cycle.
- R13: Reset clears every counter, mask, control bit, the select register and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| evt_in | input | NUM_CNT | One-cycle increment strobes, one per event counter |
| el | input | 2 | Current exception level |
| secure | input | 1 | Secure state flag |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The assertions assume that the control reset bits and a count write never target the same counter in the same cycle. The port allows only one address per cycle, so that case cannot occur. They also assume that `evt_in`, `el` and `secure` change only between clock edges, so a filter decision is stable across the edge it affects. The bench changes every input on the falling edge and reads results on the falling edge after the edge that updates them. While the cycle counter is being loaded near a wrap point, the bench keeps it disabled, so its exact value never depends on timing.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_EN_SET = 4'd1;
    localparam logic [3:0] A_EN_CLR = 4'd2;
    localparam logic [3:0] A_IE_SET = 4'd3;
    localparam logic [3:0] A_IE_CLR = 4'd4;
    localparam logic [3:0] A_OV_SET = 4'd5;
    localparam logic [3:0] A_OV_CLR = 4'd6;
    localparam logic [3:0] A_SWINC  = 4'd7;
    localparam logic [3:0] A_SEL    = 4'd8;
    localparam logic [3:0] A_TYPE   = 4'd9;
    localparam logic [3:0] A_COUNT  = 4'd10;
    localparam logic [3:0] A_CYC_LO = 4'd11;
    localparam logic [3:0] A_CYC_HI = 4'd12;

    localparam int CB_EN   = 0;
    localparam int CB_EVRS = 1;
    localparam int CB_CYRS = 2;
    localparam int CB_LONG = 5;
    localparam logic [31:0] CTRL_MASK = 32'h0000_0039;

    // filter vector order: P U NSK NSU NSH M (bit 5 .. bit 0)
    localparam int FLT_LSB = 26;

    typedef struct packed {
        logic [31:0] cnt;
        logic [5:0]  filt;
        logic [7:0]  evt;
    } slice_state_t;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] en;
        logic [31:0] ie;
        logic [31:0] ov;
        logic [4:0]  sel;
        logic        irq;
        logic [63:0] cyc;
        logic [5:0]  cyc_filt;
    } unit_state_t;

endpackage

// File: rtl/perfmon_filter.sv
module perfmon_filter (
    input  logic [5:0] filt,
    input  logic [1:0] el,
    input  logic       secure,
    output logic       hold
);
    logic f_p, f_u, f_nsk, f_nsu, f_nsh, f_m;

    always_comb begin
        {f_p, f_u, f_nsk, f_nsu, f_nsh, f_m} = filt;
        case (el)
            2'd0:    hold = secure ? f_u : (f_u ^ f_nsu);
            2'd1:    hold = secure ? f_p : (f_p ^ f_nsk);
            2'd2:    hold = ~f_nsh;
            default: hold = f_p ^ f_m;
        endcase
    end
endmodule

// File: rtl/perfmon_slice.sv
module perfmon_slice
    import perfmon_pkg::*;
#(
    parameter logic [7:0] SW_CODE = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  el,
    input  logic        secure,
    input  logic        run,
    input  logic        evt_pulse,
    input  logic        sw_pulse,
    input  logic        clr,
    input  logic        type_we,
    input  logic [5:0]  filt_wd,
    input  logic [7:0]  evt_wd,
    input  logic        cnt_we,
    input  logic [31:0] cnt_wd,
    output logic [31:0] cnt_q,
    output logic [31:0] type_q,
    output logic        ovf
);
    slice_state_t s_d, s_q;
    logic blk, inc, over;

    perfmon_filter u_filt (
        .filt   (s_q.filt),
        .el     (el),
        .secure (secure),
        .hold   (blk)
    );

    always_comb begin
        s_d  = s_q;
        over = clr | cnt_we;
        inc  = run & ~blk & (evt_pulse | (sw_pulse & (s_q.evt == SW_CODE)));
        if (clr)         s_d.cnt = '0;
        else if (cnt_we) s_d.cnt = cnt_wd;
        else if (inc)    s_d.cnt = s_q.cnt + 32'd1;
        if (type_we) begin
            s_d.filt = filt_wd;
            s_d.evt  = evt_wd;
        end
        ovf = inc & ~over & (s_q.cnt == 32'hFFFF_FFFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q  = s_q.cnt;
    assign type_q = {s_q.filt, 18'd0, s_q.evt};

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !clr) |=> (cnt_q == $past(cnt_wd))); // R12
    AST_EVT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == 32'd0)); // R2
    AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we && !clr) |=> $stable(cnt_q)); // R3
    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !cnt_we && !clr) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int         NUM_CNT  = 6,
    parameter logic [7:0] ID_CODE  = 8'h5A,
    parameter logic [7:0] SW_CODE  = 8'h00,
    parameter logic [7:0] CYC_CODE = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_CNT-1:0] evt_in,
    input  logic [1:0]         el,
    input  logic               secure,
    output logic               irq
);
    localparam int          CYC_BIT   = 31;
    localparam logic [4:0]  CYC_SEL   = 5'd31;
    localparam logic [31:0] IMPL_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_CNT) - 32'h1);
    localparam logic [31:0] ID_FIELD  = {ID_CODE, 8'd0, 5'(NUM_CNT), 11'd0};

    unit_state_t s_d, s_q;

    logic [31:0] cnt_arr  [NUM_CNT];
    logic [31:0] type_arr [NUM_CNT];
    logic [NUM_CNT-1:0] ovf_v;
    logic cyc_blk, cyc_run, cyc_ovf;
    logic [31:0] ovf_all, ov_w;
    logic wr_ctrl, wr_swinc, wr_type, wr_count, sel_cyc;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_swinc = wr_en && (addr == A_SWINC);
    assign wr_type  = wr_en && (addr == A_TYPE);
    assign wr_count = wr_en && (addr == A_COUNT);
    assign sel_cyc  = (s_q.sel == CYC_SEL);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slice
        perfmon_slice #(.SW_CODE(SW_CODE)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .el        (el),
            .secure    (secure),
            .run       (s_q.ctrl[CB_EN] & s_q.en[i]),
            .evt_pulse (evt_in[i]),
            .sw_pulse  (wr_swinc & wdata[i]),
            .clr       (wr_ctrl & wdata[CB_EVRS]),
            .type_we   (wr_type && (s_q.sel == 5'(i))),
            .filt_wd   (wdata[FLT_LSB +: 6]),
            .evt_wd    (wdata[7:0]),
            .cnt_we    (wr_count && (s_q.sel == 5'(i))),
            .cnt_wd    (wdata),
            .cnt_q     (cnt_arr[i]),
            .type_q    (type_arr[i]),
            .ovf       (ovf_v[i])
        );
    end

    perfmon_filter u_cyc_filt (
        .filt   (s_q.cyc_filt),
        .el     (el),
        .secure (secure),
        .hold   (cyc_blk)
    );

    assign cyc_run = s_q.ctrl[CB_EN] & s_q.en[CYC_BIT] & ~cyc_blk;

    always_comb begin
        s_d     = s_q;
        cyc_ovf = 1'b0;
        if (wr_ctrl) s_d.ctrl = wdata & CTRL_MASK;
        if (wr_en && addr == A_EN_SET) s_d.en = s_q.en | (wdata & IMPL_MASK);
        if (wr_en && addr == A_EN_CLR) s_d.en = s_q.en & ~wdata;
        if (wr_en && addr == A_IE_SET) s_d.ie = s_q.ie | (wdata & IMPL_MASK);
        if (wr_en && addr == A_IE_CLR) s_d.ie = s_q.ie & ~wdata;
        if (wr_en && addr == A_SEL)    s_d.sel = wdata[4:0];
        if (wr_type && sel_cyc)        s_d.cyc_filt = wdata[FLT_LSB +: 6];

        if (wr_ctrl && wdata[CB_CYRS])            s_d.cyc = '0;
        else if (wr_en && addr == A_CYC_LO)       s_d.cyc[31:0] = wdata;
        else if (wr_en && addr == A_CYC_HI)       s_d.cyc[63:32] = wdata;
        else if (cyc_run) begin
            s_d.cyc = s_q.cyc + 64'd1;
            cyc_ovf = s_q.ctrl[CB_LONG] ? (s_q.cyc == '1) : (s_q.cyc[31:0] == '1);
        end

        ov_w = s_q.ov;
        if (wr_en && addr == A_OV_SET) ov_w = s_q.ov | (wdata & IMPL_MASK);
        if (wr_en && addr == A_OV_CLR) ov_w = s_q.ov & ~wdata;
        ovf_all = 32'(ovf_v) | ({31'd0, cyc_ovf} << CYC_BIT);

        if (wr_en && (addr == A_OV_SET || addr == A_OV_CLR)) begin
            if (s_q.ov != '0 && ov_w == '0)
                s_d.irq = 1'b0;
            else if (s_q.ov == '0 && (ov_w & s_q.ie) != '0)
                s_d.irq = 1'b1;
        end
        if ((ovf_all & s_q.ie) != '0) s_d.irq = 1'b1;
        s_d.ov = ov_w | ovf_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:             rdata = s_q.ctrl | ID_FIELD;
            A_EN_SET, A_EN_CLR: rdata = s_q.en;
            A_IE_SET, A_IE_CLR: rdata = s_q.ie;
            A_OV_SET, A_OV_CLR: rdata = s_q.ov;
            A_SEL:              rdata = {27'd0, s_q.sel};
            A_TYPE: begin
                if (sel_cyc) rdata = {s_q.cyc_filt, 18'd0, CYC_CODE};
                for (int i = 0; i < NUM_CNT; i++)
                    if (s_q.sel == 5'(i)) rdata = type_arr[i];
            end
            A_COUNT: begin
                for (int i = 0; i < NUM_CNT; i++)
                    if (s_q.sel == 5'(i)) rdata = cnt_arr[i];
            end
            A_CYC_LO:           rdata = s_q.cyc[31:0];
            A_CYC_HI:           rdata = s_q.cyc[63:32];
            default:            rdata = '0;
        endcase
    end

    assign irq = s_q.irq;

    AST_IRQ_NEEDS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.ov != '0)); // R7
    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_OV_CLR) |=> ((s_q.ov & $past(s_q.ov)) == $past(s_q.ov))); // R5
    AST_OVF_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_all & s_q.ie) != '0) |=> irq); // R6
endmodule

// File: tb/sim_perfmon_unit.sv
module sim_perfmon_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    localparam logic [3:0] CTRL = 4'd0, ENS = 4'd1, ENC = 4'd2, IES = 4'd3, IEC = 4'd4,
                           OVS = 4'd5, OVC = 4'd6, SWI = 4'd7, SEL = 4'd8, TYP = 4'd9,
                           CNT = 4'd10, CLO = 4'd11, CHI = 4'd12;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, secure = 1'b0;
    logic [3:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [N-1:0] evt_in = '0;
    logic [1:0] el = 2'd0;
    logic irq;
    int checks = 0, errors = 0;
    logic [31:0] v;

    perfmon_unit #(.NUM_CNT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_in(evt_in), .el(el), .secure(secure), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input int i);
        evt_in[i] = 1'b1;
        @(negedge clk);
        evt_in[i] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        rd(CTRL, v); chk("R13 R1 ctrl after reset", v, 32'h5A00_3000);
        rd(ENS, v);  chk("R13 enable after reset", v, 32'h0);
        rd(OVC, v);  chk("R13 overflow after reset", v, 32'h0);
        rd(CLO, v);  chk("R13 cycle after reset", v, 32'h0);
        chk("R13 irq after reset", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_ctrl;
        wr(CTRL, 32'hFFFF_FFFF); rd(CTRL, v); chk("R1 ctrl mask", v, 32'h5A00_3039);
        wr(CTRL, 32'h0);         rd(CTRL, v); chk("R1 ctrl cleared", v, 32'h5A00_3000);
    endtask

    task automatic t_setclr;
        wr(ENS, 32'h8000_0005); rd(ENC, v); chk("R4 enable set", v, 32'h8000_0005);
        wr(ENC, 32'h1);         rd(ENS, v); chk("R4 enable clear", v, 32'h8000_0004);
        wr(ENS, 32'h0000_FFFF); rd(ENS, v); chk("R4 unimplemented bits", v, 32'h8000_003F);
        wr(ENC, 32'hFFFF_FFFF); rd(ENS, v); chk("R4 enable all clear", v, 32'h0);
        wr(IES, 32'h2);         rd(IEC, v); chk("R4 int-enable set", v, 32'h2);
        wr(IEC, 32'h2);         rd(IES, v); chk("R4 int-enable clear", v, 32'h0);
    endtask

    task automatic t_gate;
        wr(SEL, 0); wr(TYP, 0); wr(ENS, 32'h1); wr(CTRL, 0);
        pulse(0); rd(CNT, v); chk("R3 global off", v, 32'h0);
        wr(CTRL, 32'h1);
        pulse(0); rd(CNT, v); chk("R3 both on", v, 32'h1);
        wr(ENC, 32'h1);
        pulse(0); rd(CNT, v); chk("R3 own bit off", v, 32'h1);
    endtask

    task automatic t_evt_ovf;
        wr(ENS, 32'h1); wr(CTRL, 32'h1); wr(SEL, 0);
        wr(CNT, 32'hFFFF_FFFF); wr(IES, 32'h1);
        pulse(0);
        rd(CNT, v); chk("R5 wrap to zero", v, 32'h0);
        rd(OVS, v); chk("R5 overflow bit", v, 32'h1);
        chk("R6 irq on overflow", {31'd0, irq}, 32'h1);
    endtask

    task automatic t_ov_write;
        wr(OVC, 32'h1);  chk("R7 clear to zero drops irq", {31'd0, irq}, 32'h0);
        wr(OVS, 32'h2);  chk("R7 no shared bit keeps irq low", {31'd0, irq}, 32'h0);
        wr(OVC, 32'h2);
        wr(OVS, 32'h1);  chk("R7 shared bit raises irq", {31'd0, irq}, 32'h1);
        wr(OVC, 32'h1);  chk("R7 cleared again", {31'd0, irq}, 32'h0);
        wr(IEC, 32'hFFFF_FFFF); wr(CNT, 32'hFFFF_FFFF);
        pulse(0);
        rd(OVS, v); chk("R6 ovf without int-enable", v, 32'h1);
        chk("R6 irq stays low", {31'd0, irq}, 32'h0);
        wr(OVC, 32'hFFFF_FFFF);
    endtask

    task automatic t_swinc;
        wr(SEL, 1); wr(TYP, 32'h0); wr(CNT, 0);
        wr(SEL, 2); wr(TYP, 32'h5); wr(CNT, 0);
        wr(ENS, 32'h6); wr(CTRL, 32'h1);
        wr(SWI, 32'h6);
        wr(SEL, 1); rd(CNT, v); chk("R8 swinc code counts", v, 32'h1);
        wr(SEL, 2); rd(CNT, v); chk("R8 other code ignored", v, 32'h0);
        wr(SWI, 32'h4);
        wr(SEL, 1); rd(CNT, v); chk("R8 unselected bit", v, 32'h1);
        rd(SWI, v); chk("R8 reads zero", v, 32'h0);
    endtask

    task automatic t_filter;
        wr(SEL, 0); wr(CNT, 0); wr(ENS, 32'h1); wr(CTRL, 32'h1);
        el = 2'd0; secure = 1'b1; wr(TYP, 32'h4000_0000);
        pulse(0); rd(CNT, v); chk("R9 el0 secure U", v, 32'h0);
        secure = 1'b0;
        pulse(0); rd(CNT, v); chk("R9 el0 U xor NSU", v, 32'h0);
        wr(TYP, 32'h5000_0000);
        pulse(0); rd(CNT, v); chk("R9 el0 U and NSU counts", v, 32'h1);
        el = 2'd2; wr(TYP, 32'h0);
        pulse(0); rd(CNT, v); chk("R9 el2 NSH clear", v, 32'h1);
        wr(TYP, 32'h0800_0000);
        pulse(0); rd(CNT, v); chk("R9 el2 NSH set", v, 32'h2);
        el = 2'd3; wr(TYP, 32'h8000_0000);
        pulse(0); rd(CNT, v); chk("R9 el3 P xor M", v, 32'h2);
        wr(TYP, 32'h8400_0000);
        pulse(0); rd(CNT, v); chk("R9 el3 P and M counts", v, 32'h3);
        el = 2'd1; secure = 1'b1; wr(TYP, 32'h8000_0000);
        pulse(0); rd(CNT, v); chk("R9 el1 secure P", v, 32'h3);
        secure = 1'b0; wr(TYP, 32'hA000_0000);
        pulse(0); rd(CNT, v); chk("R9 el1 P and NSK counts", v, 32'h4);
        el = 2'd0; wr(TYP, 32'h0);
    endtask

    task automatic t_types;
        wr(SEL, 31); wr(TYP, 32'hFC00_00FF);
        rd(TYP, v); chk("R10 cycle filter only", v, 32'hFC00_0011);
        wr(TYP, 32'h0);
        wr(SEL, 7); wr(TYP, 32'h1234_5678);
        rd(TYP, v); chk("R10 missing type reads zero", v, 32'h0);
        wr(CNT, 32'h5);
        rd(CNT, v); chk("R10 missing count reads zero", v, 32'h0);
    endtask

    task automatic t_indirect;
        wr(SEL, 3); rd(SEL, v); chk("R11 select readback", v, 32'h3);
        wr(CNT, 32'hABCD);
        wr(SEL, 4); rd(CNT, v); chk("R11 other counter", v, 32'h0);
        wr(SEL, 3); rd(CNT, v); chk("R11 selected counter", v, 32'hABCD);
    endtask

    task automatic t_priority;
        wr(SEL, 0); wr(TYP, 0); wr(ENS, 32'h1); wr(CTRL, 32'h1);
        @(negedge clk);
        evt_in[0] = 1'b1; wr_en = 1'b1; addr = CNT; wdata = 32'h5;
        @(negedge clk);
        evt_in[0] = 1'b0; wr_en = 1'b0;
        rd(CNT, v); chk("R12 count write wins", v, 32'h5);
        @(negedge clk);
        evt_in[0] = 1'b1; wr_en = 1'b1; addr = CTRL; wdata = 32'h3;
        @(negedge clk);
        evt_in[0] = 1'b0; wr_en = 1'b0;
        rd(CNT, v); chk("R12 R2 event reset wins", v, 32'h0);
    endtask

    task automatic t_cycle;
        wr(CTRL, 0); wr(ENC, 32'hFFFF_FFFF); wr(IEC, 32'hFFFF_FFFF); wr(OVC, 32'hFFFF_FFFF);
        wr(CLO, 32'hFFFF_FFFE); wr(CHI, 0); wr(ENS, 32'h8000_0000);
        wr(CTRL, 32'h1); idle(3); wr(CTRL, 0);
        rd(OVS, v); chk("R5 cycle 32-bit overflow", v, 32'h8000_0000);
        rd(CHI, v); chk("R5 cycle carries into high", v, 32'h1);
        wr(OVC, 32'hFFFF_FFFF);
        wr(CLO, 32'hFFFF_FFFE); wr(CHI, 0);
        wr(CTRL, 32'h21); idle(3); wr(CTRL, 32'h20);
        rd(OVS, v); chk("R5 long mode no 32-bit overflow", v, 32'h0);
        wr(CLO, 32'hFFFF_FFFE); wr(CHI, 32'hFFFF_FFFF);
        wr(CTRL, 32'h21); idle(3); wr(CTRL, 32'h20);
        rd(OVS, v); chk("R5 long mode 64-bit overflow", v, 32'h8000_0000);
        rd(CHI, v); chk("R5 long mode high wraps", v, 32'h0);
        wr(CTRL, 32'h4);
        rd(CLO, v); chk("R2 cycle reset low", v, 32'h0);
        rd(CHI, v); chk("R2 cycle reset high", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_ctrl;
        t_setclr;
        t_gate;
        t_evt_ovf;
        t_ov_write;
        t_swinc;
        t_filter;
        t_types;
        t_indirect;
        t_priority;
        t_cycle;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule